// File: doc/BRIEF.md
# Time-of-Day Counter with Button Adjust

This block keeps the time of day as six BCD digits (hours, minutes, seconds) in 24-hour form. The time moves forward by one second on each cycle in which the one-cycle enable `tick_1hz` is high. Seconds carry into minutes, and minutes carry into hours. Another block in the same clock domain generates the tick.

Two active-high push buttons, plus and minus, act according to a registered 2-bit adjust mode:

- In the seconds mode, either button zeroes the seconds.
- In the minutes mode and the hours mode, the buttons step that field up or down. The step wraps inside the field and never carries into a neighbour.
- In the style mode, the buttons step two small indices that a display stage uses to pick its layout and its colour set.

Each button passes through a synchroniser and a rising-edge detector, so one press acts exactly once however long it is held. The registered mode is also brought out for debug.

Top module: `timekeep_top`

## Requirements
- R1: While `rst_n` is low and after it rises, the time reads 00:00:00, `layout_idx` and `color_idx` are 0, and `mode_dbg` is 2'b00.
- R2: Each cycle with `tick_1hz` high advances the seconds by one. Seconds go 59→00 and carry one into minutes. Minutes go 59→00 and carry one into hours. Hours go 23→00, so 23:59:59 becomes 00:00:00. Each field is two BCD digits, tens and ones, 4 bits each.
- R3: In mode 2'b00, a plus or minus press sets the seconds to 00 and leaves minutes and hours unchanged.
- R4: In mode 2'b01, plus adds one minute (59→00) and minus subtracts one (00→59). Hours never change as a result.
- R5: In mode 2'b10, plus adds one hour (23→00) and minus subtracts one (00→23). Minutes never change as a result.
- R6: In mode 2'b11, plus steps `layout_idx` by one modulo 2^LAYOUT_W and minus steps `color_idx` by one modulo 2^COLOR_W. The time is not changed by either button. Outside this mode, the two indices hold.
- R7: A button sampled high at a rising clock edge k takes effect at edge k+SYNC_STAGES (edge k+2 by default), and not earlier. Holding the button high for any length of time acts once only.
- R8: When a button action and a tick fall on the same edge, the button action is applied. Fields the button does not touch still advance on the tick. A carry into a field that the button sets is dropped. For example, a seconds clear on a tick leaves seconds at 00; a minute step on a tick at second 59 gives seconds 00 and the minutes changed by the step only.
- R9: In modes 2'b01 and 2'b10, if plus and minus rise on the same edge, plus wins and the field steps up.
- R10: `mode_sel` is registered once. `mode_dbg` shows it from the next edge on, and button actions decode this registered value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| tick_1hz | input | 1 | One-cycle enable that advances the time by a second |
| btn_plus | input | 1 | Plus push button, active high, asynchronous |
| btn_minus | input | 1 | Minus push button, active high, asynchronous |
| mode_sel | input | 2 | Adjust mode: 00 seconds, 01 minutes, 10 hours, 11 style |
| hr_tens | output | 4 | Hours tens digit (BCD) |
| hr_ones | output | 4 | Hours ones digit (BCD) |
| mn_tens | output | 4 | Minutes tens digit (BCD) |
| mn_ones | output | 4 | Minutes ones digit (BCD) |
| sc_tens | output | 4 | Seconds tens digit (BCD) |
| sc_ones | output | 4 | Seconds ones digit (BCD) |
| layout_idx | output | LAYOUT_W | Display layout index |
| color_idx | output | COLOR_W | Display colour index |
| mode_dbg | output | 2 | Registered adjust mode, for debug |

## Verification
The counting path is driven by long runs of single ticks. These runs separate the ones-digit wrap inside a field from the carry between fields. The full 23:59:59 case shows that all three fields wrap on one edge.

Button steps are applied from both ends of each field (00 and the maximum) to show that a manual step wraps without carrying or borrowing. A long hold shows that a press acts once, and cycle-exact sampling around the press pins down when the step lands.

Presses timed to land on the same edge as a tick, and presses of both buttons together, separate the collision rule and the plus-first rule from ordinary stepping. The style mode is tried with runs of presses longer than the index range, so that the modulo wrap is seen.

// File: rtl/timekeep_pkg.sv
package timekeep_pkg;

  // Two BCD digits packed as {tens, ones}.
  typedef logic [7:0] bcd2_t;

  typedef enum logic [1:0] {
    MODE_SEC   = 2'b00,
    MODE_MIN   = 2'b01,
    MODE_HOUR  = 2'b10,
    MODE_STYLE = 2'b11
  } adj_mode_e;

  // Binary value 0..99 to packed BCD.
  function automatic bcd2_t bcd2_of(input int unsigned n);
    bcd2_t r;
    r[7:4] = 4'(n / 10);
    r[3:0] = 4'(n % 10);
    return r;
  endfunction

  // Step up inside 0..top, wrapping to zero.
  function automatic bcd2_t bcd2_inc(input bcd2_t v, input int unsigned top);
    bcd2_t r;
    if (v == bcd2_of(top))    r = 8'h00;
    else if (v[3:0] == 4'd9)  r = {v[7:4] + 4'd1, 4'd0};
    else                      r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Step down inside 0..top, wrapping to top.
  function automatic bcd2_t bcd2_dec(input bcd2_t v, input int unsigned top);
    bcd2_t r;
    if (v == 8'h00)           r = bcd2_of(top);
    else if (v[3:0] == 4'd0)  r = {v[7:4] - 4'd1, 4'd9};
    else                      r = {v[7:4], v[3:0] - 4'd1};
    return r;
  endfunction

endpackage

// File: rtl/tk_press_edge.sv
module tk_press_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              level;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign level = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= level;
  end

  assign rise = level & ~last_q;

  // R7: an edge pulse never lasts two cycles.
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/tk_bcd_field.sv
module tk_bcd_field
  import timekeep_pkg::*;
#(
  parameter int unsigned TOP = 59
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  inc_req,
  input  logic  dec_req,
  input  logic  adv,
  output bcd2_t value,
  output logic  carry
);

  localparam bcd2_t TOP_BCD = bcd2_of(TOP);

  bcd2_t value_q;
  bcd2_t value_d;
  logic  manual;

  assign manual = clr | inc_req | dec_req;

  always_comb begin
    value_d = value_q;
    if (clr)          value_d = 8'h00;
    else if (inc_req) value_d = bcd2_inc(value_q, TOP);
    else if (dec_req) value_d = bcd2_dec(value_q, TOP);
    else if (adv)     value_d = bcd2_inc(value_q, TOP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) value_q <= 8'h00;
    else        value_q <= value_d;
  end

  // A manual change to this field swallows the carry it would have passed on.
  assign carry = adv & ~manual & (value_q == TOP_BCD);
  assign value = value_q;

  assert_legal_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (value_q[3:0] <= 4'd9) && (value_q <= TOP_BCD));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(manual || adv) |=> $stable(value_q));

  assert_carry_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> (value_q == 8'h00));

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (value_q == 8'h00));

  assert_down_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && !clr && !inc_req && value_q == 8'h00) |=> (value_q == TOP_BCD));

endmodule

// File: rtl/timekeep_top.sv
module timekeep_top
  import timekeep_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LAYOUT_W    = 2,
  parameter int COLOR_W     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_1hz,
  input  logic                btn_plus,
  input  logic                btn_minus,
  input  logic [1:0]          mode_sel,
  output logic [3:0]          hr_tens,
  output logic [3:0]          hr_ones,
  output logic [3:0]          mn_tens,
  output logic [3:0]          mn_ones,
  output logic [3:0]          sc_tens,
  output logic [3:0]          sc_ones,
  output logic [LAYOUT_W-1:0] layout_idx,
  output logic [COLOR_W-1:0]  color_idx,
  output logic [1:0]          mode_dbg
);

  localparam int NUM_BTN = 2;
  localparam int BTN_P   = 0;
  localparam int BTN_M   = 1;

  // Button front end: one synchroniser and edge detector per button.
  logic [NUM_BTN-1:0] btn_raw;
  logic [NUM_BTN-1:0] btn_rise;

  assign btn_raw = {btn_minus, btn_plus};

  for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
    tk_press_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (btn_raw[b]),
      .rise (btn_rise[b])
    );
  end

  logic rise_p;
  logic rise_m;
  assign rise_p = btn_rise[BTN_P];
  assign rise_m = btn_rise[BTN_M];

  // Registered adjust mode.
  adj_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_SEC;
    else        mode_q <= adj_mode_e'(mode_sel);
  end

  // Named adjust events.
  logic sec_clr;
  logic min_up, min_dn;
  logic hr_up, hr_dn;
  logic layout_step, color_step;

  assign sec_clr     = (mode_q == MODE_SEC)   & (rise_p | rise_m);
  assign min_up      = (mode_q == MODE_MIN)   & rise_p;
  assign min_dn      = (mode_q == MODE_MIN)   & rise_m & ~rise_p;
  assign hr_up       = (mode_q == MODE_HOUR)  & rise_p;
  assign hr_dn       = (mode_q == MODE_HOUR)  & rise_m & ~rise_p;
  assign layout_step = (mode_q == MODE_STYLE) & rise_p;
  assign color_step  = (mode_q == MODE_STYLE) & rise_m;

  // Time fields.
  bcd2_t sec_v, min_v, hr_v;
  logic  sec_carry, min_carry, day_wrap;

  tk_bcd_field #(.TOP(59)) u_sec (
    .clk(clk), .rst_n(rst_n),
    .clr(sec_clr), .inc_req(1'b0), .dec_req(1'b0),
    .adv(tick_1hz), .value(sec_v), .carry(sec_carry)
  );

  tk_bcd_field #(.TOP(59)) u_min (
    .clk(clk), .rst_n(rst_n),
    .clr(1'b0), .inc_req(min_up), .dec_req(min_dn),
    .adv(sec_carry), .value(min_v), .carry(min_carry)
  );

  tk_bcd_field #(.TOP(23)) u_hr (
    .clk(clk), .rst_n(rst_n),
    .clr(1'b0), .inc_req(hr_up), .dec_req(hr_dn),
    .adv(min_carry), .value(hr_v), .carry(day_wrap)
  );

  // Display style indices.
  logic [LAYOUT_W-1:0] layout_q;
  logic [COLOR_W-1:0]  color_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      layout_q <= '0;
      color_q  <= '0;
    end else begin
      if (layout_step) layout_q <= layout_q + 1'b1;
      if (color_step)  color_q  <= color_q + 1'b1;
    end
  end

  assign hr_tens    = hr_v[7:4];
  assign hr_ones    = hr_v[3:0];
  assign mn_tens    = min_v[7:4];
  assign mn_ones    = min_v[3:0];
  assign sc_tens    = sec_v[7:4];
  assign sc_ones    = sec_v[3:0];
  assign layout_idx = layout_q;
  assign color_idx  = color_q;
  assign mode_dbg   = mode_q;

  // Checks next to the logic they guard.
  assert_day_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    day_wrap |=> (hr_v == 8'h00 && min_v == 8'h00 && sec_v == 8'h00));

  assert_min_no_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_MIN && (rise_p || rise_m)) |=> $stable(hr_v));

  assert_hr_keeps_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_HOUR && (rise_p || rise_m) && !tick_1hz) |=> $stable(min_v));

  assert_style_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_STYLE) |=> ($stable(layout_q) && $stable(color_q)));

  assert_style_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STYLE && !tick_1hz) |=> ($stable(sec_v) && $stable(min_v) && $stable(hr_v)));

  assert_plus_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_MIN && rise_p && rise_m) |=> (min_v == bcd2_inc($past(min_v), 59)));

  assert_one_adjust_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({min_up, min_dn, hr_up, hr_dn, sec_clr}) <= 1);

endmodule

// File: tb/test_timekeep_top.sv
module test_timekeep_top;

  localparam int LAYOUT_W = 2;
  localparam int COLOR_W  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1hz = 1'b0;
  logic btn_plus = 1'b0;
  logic btn_minus = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic [3:0] hr_tens, hr_ones, mn_tens, mn_ones, sc_tens, sc_ones;
  logic [LAYOUT_W-1:0] layout_idx;
  logic [COLOR_W-1:0]  color_idx;
  logic [1:0] mode_dbg;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  timekeep_top #(.SYNC_STAGES(2), .LAYOUT_W(LAYOUT_W), .COLOR_W(COLOR_W)) i_timekeep_top (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
    .btn_plus(btn_plus), .btn_minus(btn_minus), .mode_sel(mode_sel),
    .hr_tens(hr_tens), .hr_ones(hr_ones), .mn_tens(mn_tens), .mn_ones(mn_ones),
    .sc_tens(sc_tens), .sc_ones(sc_ones),
    .layout_idx(layout_idx), .color_idx(color_idx), .mode_dbg(mode_dbg)
  );

  // Time as hhmmss decimal.
  function automatic int now_hms();
    return (hr_tens * 10 + hr_ones) * 10000 + (mn_tens * 10 + mn_ones) * 100
           + (sc_tens * 10 + sc_ones);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_1hz = 1'b1;
      @(negedge clk) tick_1hz = 1'b0;
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk) mode_sel = m;
    @(negedge clk);
  endtask

  task automatic press(input bit p, input bit m);
    @(negedge clk) begin btn_plus = p; btn_minus = m; end
    repeat (4) @(negedge clk);
    btn_plus = 1'b0; btn_minus = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 time", now_hms(), 0);
    chk("R1 layout", int'(layout_idx), 0);
    chk("R1 color", int'(color_idx), 0);
    chk("R1 mode", int'(mode_dbg), 0);
  endtask

  task automatic t_mode_reg();
    @(negedge clk) mode_sel = 2'b10;
    @(negedge clk);
    chk("R10 mode_dbg", int'(mode_dbg), 2);
    set_mode(2'b00);
    chk("R10 mode_dbg back", int'(mode_dbg), 0);
  endtask

  task automatic t_count();
    ticks(5);
    chk("R2 five ticks", now_hms(), 5);
    ticks(55);
    chk("R2 carry to minutes", now_hms(), 100);
  endtask

  task automatic t_clear();
    set_mode(2'b00);
    ticks(7);
    press(1, 0);
    chk("R3 plus clears", now_hms(), 100);
    ticks(3);
    press(0, 1);
    chk("R3 minus clears", now_hms(), 100);
  endtask

  task automatic t_minutes();
    set_mode(2'b01);
    press(1, 0);
    chk("R4 plus", now_hms(), 200);
    press(0, 1);
    press(0, 1);
    press(0, 1);
    chk("R4 minus wraps no borrow", now_hms(), 5900);
    press(1, 0);
    chk("R4 plus wraps no carry", now_hms(), 0);
  endtask

  task automatic t_hours();
    set_mode(2'b10);
    press(0, 1);
    chk("R5 minus wraps", now_hms(), 230000);
    press(1, 0);
    chk("R5 plus wraps", now_hms(), 0);
    press(1, 0);
    press(1, 0);
    chk("R5 plus twice", now_hms(), 20000);
  endtask

  task automatic t_hold();
    set_mode(2'b10);
    @(negedge clk) btn_plus = 1'b1;   // sampled at the next edge (k)
    @(negedge clk);                   // after k
    @(negedge clk);                   // after k+1
    chk("R7 not yet", now_hms(), 20000);
    @(negedge clk);                   // after k+2
    chk("R7 lands at k+2", now_hms(), 30000);
    repeat (20) @(negedge clk);
    chk("R7 held acts once", now_hms(), 30000);
    btn_plus = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_rollover();
    set_mode(2'b10);
    press(0, 1); press(0, 1); press(0, 1); press(0, 1);
    set_mode(2'b01);
    press(0, 1);
    ticks(59);
    chk("R2 set 23:59:59", now_hms(), 235959);
    ticks(1);
    chk("R2 day wrap", now_hms(), 0);
  endtask

  task automatic t_style();
    set_mode(2'b11);
    ticks(4);
    for (int i = 0; i < 5; i++) press(1, 0);
    chk("R6 layout mod", int'(layout_idx), 1);
    for (int i = 0; i < 9; i++) press(0, 1);
    chk("R6 color mod", int'(color_idx), 1);
    chk("R6 time untouched", now_hms(), 4);
    set_mode(2'b00);
    press(1, 1);
    chk("R6 layout held", int'(layout_idx), 1);
    chk("R6 color held", int'(color_idx), 1);
  endtask

  // Button set at a negedge, tick placed on the edge where the action lands.
  task automatic press_on_tick(input bit p, input bit m);
    @(negedge clk) begin btn_plus = p; btn_minus = m; end
    @(negedge clk);
    @(negedge clk) tick_1hz = 1'b1;
    @(negedge clk) tick_1hz = 1'b0;
    btn_plus = 1'b0; btn_minus = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_collide();
    ticks(59);
    chk("R8 setup", now_hms(), 59);
    set_mode(2'b01);
    press_on_tick(1, 0);
    chk("R8 minute step drops carry", now_hms(), 100);
    ticks(5);
    set_mode(2'b00);
    press_on_tick(0, 1);
    chk("R8 clear beats tick", now_hms(), 100);
  endtask

  task automatic t_priority();
    set_mode(2'b01);
    press(1, 1);
    chk("R9 plus wins minutes", now_hms(), 200);
    set_mode(2'b10);
    press(1, 1);
    chk("R9 plus wins hours", now_hms(), 10200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_reg();
    t_count();
    t_clear();
    t_minutes();
    t_hours();
    t_hold();
    t_rollover();
    t_style();
    t_collide();
    t_priority();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule